// File: doc/BRIEF.md
# Processor Power-State Sequencer

This block sequences a processor core through three power states: Working, Halt and Stop Grant. It watches a halt-instruction pulse, an active-low stop-clock request, a vector of wake events and a disconnect indication from the system controller. From these it issues single-cycle Halt and Stop Grant special-cycle requests and bus-connect requests. It does not gate any clock. It drives a low-power enable, together with the mode value copied from a clock-control input, and these apply only while the core sits in Halt or Stop Grant and the bus is disconnected.

A bus-link tracker inside the block has three states: Up (connected), Down (disconnected) and Wait (connect requested, acknowledge not yet seen). The tracker accepts a disconnect only after the special cycle for the current low state has gone out. A special-cycle issuer holds the one pending request and releases it only while the link is Up. A connect request must therefore be acknowledged before a new special cycle can be issued. A wake collector ORs the wake sources together. It also remembers a wake that arrived while stop-clock was asserted.

The main FSM states and transitions:
- Working to Halt on a halt instruction.
- Working to Stop Grant on stop-clock. Stop-clock has priority over a halt instruction in the same cycle.
- Halt to Stop Grant on stop-clock. Stop-clock has priority over a wake in the same cycle.
- Halt to Working on a wake, either present now or remembered.
- Stop Grant to Halt when stop-clock is released.
- Stop Grant stays in Stop Grant on a probe, which requests a connect.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, `pstate` is 0 (Working), `lp_en` is 0, `lp_mode` is 0 and `halt_cyc`, `sgnt_cyc` and `conn_req` are all 0. Reset overrides every other input.
- R2: A `halt_exec` pulse in Working moves `pstate` to 1 (Halt) at the next edge. If the bus is connected, exactly one `halt_cyc` pulse follows one cycle later.
- R3: `stpclk_n` low in Working moves `pstate` to 2 (Stop Grant) at the next edge, and a `sgnt_cyc` pulse follows. Stop-clock wins over a `halt_exec` in the same cycle.
- R4: `disc_ind` is honoured only in Halt or Stop Grant, and only after that state's special cycle has been issued. It is ignored in Working. `lp_en` is 1 exactly while in Halt or Stop Grant with the bus disconnected. `lp_mode` equals `clk_ctl` while `lp_en` is 1, and is 0 otherwise.
- R5: `stpclk_n` low in Halt with the bus disconnected gives one `conn_req` pulse. The `sgnt_cyc` pulse is withheld until `conn_ack` has been seen. While `conn_req` is high, `lp_en` is 0.
- R6: Releasing `stpclk_n` in Stop Grant moves `pstate` to 1 at the next edge and issues a fresh `halt_cyc`.
- R7: Any bit of `wake_src` moves Halt to Working at the next edge. The bits are: bit 0 init, bit 1 reset, bit 2 SMI, bit 3 INTR, bit 4 NMI, bit 5 local interrupt message. If the bus is disconnected at that time, one `conn_req` pulse is issued.
- R8: If a wake and stop-clock arrive in the same Halt cycle, the block enters Stop Grant. The wake is held. After release the block passes through Halt, issuing its `halt_cyc`, and enters Working one cycle later.
- R9: `probe_req` in Stop Grant with the bus disconnected produces one `conn_req` pulse. `lp_en` drops in the same cycle, and `pstate` stays at 2.
- R10: `halt_cyc`, `sgnt_cyc` and `conn_req` are each high for a single cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, never stopped |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_exec | input | 1 | Halt-instruction pulse from the core |
| stpclk_n | input | 1 | Active-low stop-clock request |
| wake_src | input | NUM_WAKE | Wake events, one bit per source |
| disc_ind | input | 1 | Bus-disconnect indication from the system controller |
| conn_ack | input | 1 | Acknowledge of a bus connect |
| probe_req | input | 1 | Probe request from the system controller |
| clk_ctl | input | CTL_W | Programmed low-power mode value |
| halt_cyc | output | 1 | Halt special-cycle request pulse |
| sgnt_cyc | output | 1 | Stop Grant special-cycle request pulse |
| conn_req | output | 1 | Bus-connect request pulse |
| lp_en | output | 1 | Low-power enable status |
| lp_mode | output | CTL_W | Mode applied while `lp_en` is high |
| pstate | output | 2 | Current state: 0 Working, 1 Halt, 2 Stop Grant |

## Verification
The stop-clock request and a wake event can reach the Halt state in the same cycle. The bench provokes this by driving an NMI wake and a stop-clock assertion on the same clock while the bus is disconnected. It then judges the result in three places. The state must read Stop Grant. The scoreboard must see the connect request before any Stop Grant cycle, and the Stop Grant cycle only after the acknowledge. After stop-clock is released, the core must return through Halt with its Halt cycle and then reach Working one cycle later. The same collision check is repeated against stop-clock and a halt instruction arriving together in Working.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_WORK = 2'd0,
        PS_HALT = 2'd1,
        PS_SGNT = 2'd2
    } pstate_t;

    typedef enum logic [1:0] {
        LK_UP   = 2'd0,
        LK_DOWN = 2'd1,
        LK_WAIT = 2'd2
    } link_t;

    typedef enum logic {
        CK_HALT = 1'b0,
        CK_SGNT = 1'b1
    } cyc_kind_t;

endpackage

// File: rtl/pwr_wake_hold.sv
module pwr_wake_hold #(
    parameter int NUM_WAKE = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WAKE-1:0] wake_src,
    input  logic                hold_set,
    input  logic                hold_clr,
    output logic                wake_now,
    output logic                wake_held
);

    logic [NUM_WAKE:0] chain;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < NUM_WAKE; i++) begin : g_or
        assign chain[i+1] = chain[i] | wake_src[i];
    end

    assign wake_now = chain[NUM_WAKE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_held <= 1'b0;
        end else if (hold_clr) begin
            wake_held <= 1'b0;
        end else if (hold_set) begin
            wake_held <= 1'b1;
        end
    end

endmodule

// File: rtl/pwr_link_ctrl.sv
module pwr_link_ctrl
    import pwr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic conn_go,
    input  logic disc_ind,
    input  logic disc_ok,
    input  logic conn_ack,
    output logic conn_req,
    output logic link_up,
    output logic link_down
);

    link_t lk_q, lk_d;
    logic  req_d;

    always_comb begin
        lk_d  = lk_q;
        req_d = 1'b0;
        unique case (lk_q)
            LK_UP: begin
                if (disc_ind && disc_ok) begin
                    lk_d = LK_DOWN;
                end
            end
            LK_DOWN: begin
                if (conn_go) begin
                    lk_d  = LK_WAIT;
                    req_d = 1'b1;
                end
            end
            LK_WAIT: begin
                if (conn_ack) begin
                    lk_d = LK_UP;
                end
            end
            default: lk_d = LK_UP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q     <= LK_UP;
            conn_req <= 1'b0;
        end else begin
            lk_q     <= lk_d;
            conn_req <= req_d;
        end
    end

    assign link_up   = (lk_q == LK_UP);
    assign link_down = (lk_q == LK_DOWN);

endmodule

// File: rtl/pwr_cyc_issuer.sv
module pwr_cyc_issuer
    import pwr_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sc_load,
    input  cyc_kind_t sc_kind,
    input  logic      sc_drop,
    input  logic      link_up,
    output logic      halt_cyc,
    output logic      sgnt_cyc,
    output logic      sc_sent
);

    logic      pend_q;
    cyc_kind_t kind_q;
    logic      fire;

    assign fire = pend_q && link_up;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            kind_q   <= CK_HALT;
            sc_sent  <= 1'b0;
            halt_cyc <= 1'b0;
            sgnt_cyc <= 1'b0;
        end else begin
            halt_cyc <= fire && (kind_q == CK_HALT);
            sgnt_cyc <= fire && (kind_q == CK_SGNT);
            if (sc_load) begin
                pend_q  <= 1'b1;
                kind_q  <= sc_kind;
                sc_sent <= 1'b0;
            end else if (sc_drop) begin
                pend_q  <= 1'b0;
                sc_sent <= 1'b0;
            end else if (fire) begin
                pend_q  <= 1'b0;
                sc_sent <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int CTL_W    = 4,
    parameter int NUM_WAKE = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt_exec,
    input  logic                stpclk_n,
    input  logic [NUM_WAKE-1:0] wake_src,
    input  logic                disc_ind,
    input  logic                conn_ack,
    input  logic                probe_req,
    input  logic [CTL_W-1:0]    clk_ctl,
    output logic                halt_cyc,
    output logic                sgnt_cyc,
    output logic                conn_req,
    output logic                lp_en,
    output logic [CTL_W-1:0]    lp_mode,
    output logic [1:0]          pstate
);

    pstate_t   st_q, st_d;
    logic      stop_req;
    logic      sc_load, sc_drop, sc_sent;
    cyc_kind_t sc_kind;
    logic      conn_go, disc_ok;
    logic      link_up, link_down;
    logic      hold_set, hold_clr, wake_now, wake_held;

    assign stop_req = ~stpclk_n;

    pwr_wake_hold #(.NUM_WAKE(NUM_WAKE)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_src  (wake_src),
        .hold_set  (hold_set),
        .hold_clr  (hold_clr),
        .wake_now  (wake_now),
        .wake_held (wake_held)
    );

    pwr_link_ctrl u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .conn_go   (conn_go),
        .disc_ind  (disc_ind),
        .disc_ok   (disc_ok),
        .conn_ack  (conn_ack),
        .conn_req  (conn_req),
        .link_up   (link_up),
        .link_down (link_down)
    );

    pwr_cyc_issuer u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .sc_load  (sc_load),
        .sc_kind  (sc_kind),
        .sc_drop  (sc_drop),
        .link_up  (link_up),
        .halt_cyc (halt_cyc),
        .sgnt_cyc (sgnt_cyc),
        .sc_sent  (sc_sent)
    );

    // Next-state and handshake decisions
    always_comb begin
        st_d     = st_q;
        sc_load  = 1'b0;
        sc_kind  = CK_HALT;
        sc_drop  = 1'b0;
        conn_go  = 1'b0;
        hold_set = 1'b0;
        hold_clr = 1'b0;
        unique case (st_q)
            PS_WORK: begin
                if (stop_req) begin
                    st_d    = PS_SGNT;
                    sc_load = 1'b1;
                    sc_kind = CK_SGNT;
                end else if (halt_exec) begin
                    st_d    = PS_HALT;
                    sc_load = 1'b1;
                    sc_kind = CK_HALT;
                end
            end
            PS_HALT: begin
                if (stop_req) begin
                    st_d     = PS_SGNT;
                    sc_load  = 1'b1;
                    sc_kind  = CK_SGNT;
                    conn_go  = 1'b1;
                    hold_set = wake_now;
                end else if (wake_now || wake_held) begin
                    st_d     = PS_WORK;
                    sc_drop  = 1'b1;
                    conn_go  = 1'b1;
                    hold_clr = 1'b1;
                end
            end
            PS_SGNT: begin
                hold_set = wake_now;
                if (!stop_req) begin
                    st_d    = PS_HALT;
                    sc_load = 1'b1;
                    sc_kind = CK_HALT;
                    conn_go = 1'b1;
                end else if (probe_req) begin
                    conn_go = 1'b1;
                end
            end
            default: st_d = PS_WORK;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PS_WORK;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs
    always_comb begin
        disc_ok = sc_sent && (st_q != PS_WORK);
        lp_en   = (st_q != PS_WORK) && link_down;
        lp_mode = lp_en ? clk_ctl : '0;
        pstate  = st_q;
    end

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int CTL_W    = 4,
    parameter int NUM_WAKE = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stpclk_n,
    input logic [NUM_WAKE-1:0] wake_src,
    input logic                halt_cyc,
    input logic                sgnt_cyc,
    input logic                conn_req,
    input logic                lp_en,
    input logic [CTL_W-1:0]    lp_mode,
    input logic [1:0]          pstate
);

    // R10
    halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cyc |=> !halt_cyc);

    // R10
    sgnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sgnt_cyc |=> !sgnt_cyc);

    // R10
    conn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conn_req |=> !conn_req);

    // R3
    work_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 2'd0 && !stpclk_n) |=> pstate == 2'd2);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 2'd2 && stpclk_n) |=> pstate == 2'd1);

    // R7
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 2'd1 && stpclk_n && (|wake_src)) |=> pstate == 2'd0);

    // R5
    conn_not_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conn_req |-> !lp_en);

    // R4
    lp_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_en |-> pstate != 2'd0);

    // R4
    mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_en |-> lp_mode == '0);

endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.CTL_W(CTL_W), .NUM_WAKE(NUM_WAKE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stpclk_n (stpclk_n),
    .wake_src (wake_src),
    .halt_cyc (halt_cyc),
    .sgnt_cyc (sgnt_cyc),
    .conn_req (conn_req),
    .lp_en    (lp_en),
    .lp_mode  (lp_mode),
    .pstate   (pstate)
);

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;

    localparam int CLK_PER  = 10;
    localparam int CTL_W    = 4;
    localparam int NUM_WAKE = 6;
    localparam int EV_CONN  = 1;
    localparam int EV_HALT  = 2;
    localparam int EV_SGNT  = 3;

    typedef struct {
        int    ev;
        string tag;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                halt_exec = 1'b0;
    logic                stpclk_n = 1'b1;
    logic [NUM_WAKE-1:0] wake_src = '0;
    logic                disc_ind = 1'b0;
    logic                conn_ack = 1'b0;
    logic                probe_req = 1'b0;
    logic [CTL_W-1:0]    clk_ctl = 4'hA;
    logic                halt_cyc, sgnt_cyc, conn_req, lp_en;
    logic [CTL_W-1:0]    lp_mode;
    logic [1:0]          pstate;

    int   nvec = 0;
    int   nerr = 0;
    logic done = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PER/2) clk = ~clk;

    pwr_seq_ctrl #(.CTL_W(CTL_W), .NUM_WAKE(NUM_WAKE)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_exec (halt_exec),
        .stpclk_n  (stpclk_n),
        .wake_src  (wake_src),
        .disc_ind  (disc_ind),
        .conn_ack  (conn_ack),
        .probe_req (probe_req),
        .clk_ctl   (clk_ctl),
        .halt_cyc  (halt_cyc),
        .sgnt_cyc  (sgnt_cyc),
        .conn_req  (conn_req),
        .lp_en     (lp_en),
        .lp_mode   (lp_mode),
        .pstate    (pstate)
    );

    task automatic check(string tag, int got, int exp);
        nvec++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic expect_ev(int ev, string tag);
        exp_t e;
        e.ev  = ev;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic take(int got);
        exp_t e;
        nvec++;
        if (exp_q.size() == 0) begin
            nerr++;
            $display("FAIL R10: unexpected pulse %0d, expected none", got);
        end else begin
            e = exp_q.pop_front();
            if (e.ev != got) begin
                nerr++;
                $display("FAIL %s: pulse %0d expected %0d", e.tag, got, e.ev);
            end
        end
    endtask

    // Monitor: pops the scoreboard as pulses appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (conn_req) take(EV_CONN);
            if (halt_cyc) take(EV_HALT);
            if (sgnt_cyc) take(EV_SGNT);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        step(3);
        // R1: outputs held during reset
        check("R1 pstate in reset", pstate, 0);
        check("R1 pulses in reset", {halt_cyc, sgnt_cyc, conn_req}, 0);
        rst_n = 1'b1;
        step(1);
        check("R1 pstate", pstate, 0);
        check("R1 lp_en", lp_en, 0);
        check("R1 lp_mode", lp_mode, 0);

        // R2: halt instruction
        expect_ev(EV_HALT, "R2 halt cycle");
        halt_exec = 1'b1;
        step(1);
        halt_exec = 1'b0;
        check("R2 pstate halt", pstate, 1);
        step(1);
        // R4: disconnect after halt cycle
        disc_ind = 1'b1;
        step(1);
        disc_ind = 1'b0;
        check("R4 lp_en halt", lp_en, 1);
        check("R4 lp_mode", lp_mode, 'hA);

        // R7: INTR wake (bit 3) with bus down
        expect_ev(EV_CONN, "R7 connect");
        wake_src = 6'b001000;
        step(1);
        wake_src = '0;
        check("R7 pstate work", pstate, 0);
        check("R7 lp_en", lp_en, 0);
        conn_ack = 1'b1;
        step(1);
        conn_ack = 1'b0;

        // R4: disconnect ignored in Working
        disc_ind = 1'b1;
        step(1);
        disc_ind = 1'b0;
        check("R4 ignored lp_en", lp_en, 0);
        expect_ev(EV_HALT, "R4 bus still up");
        halt_exec = 1'b1;
        step(1);
        halt_exec = 1'b0;
        step(1);
        disc_ind = 1'b1;
        step(1);
        disc_ind = 1'b0;
        check("R4 lp_en halt2", lp_en, 1);

        // R8/R5: stop-clock and NMI (bit 4) together, bus down
        expect_ev(EV_CONN, "R5 connect first");
        stpclk_n = 1'b0;
        wake_src = 6'b010000;
        step(1);
        wake_src = '0;
        check("R8 pstate sgnt", pstate, 2);
        step(2);
        expect_ev(EV_SGNT, "R5 sgnt after ack");
        conn_ack = 1'b1;
        step(1);
        conn_ack = 1'b0;
        step(1);
        check("R8 wake held", pstate, 2);
        disc_ind = 1'b1;
        step(1);
        disc_ind = 1'b0;
        check("R4 lp_en sgnt", lp_en, 1);

        // R9: probe while disconnected
        expect_ev(EV_CONN, "R9 probe connect");
        probe_req = 1'b1;
        step(1);
        probe_req = 1'b0;
        check("R9 lp_en drop", lp_en, 0);
        check("R9 pstate", pstate, 2);
        conn_ack = 1'b1;
        step(1);
        conn_ack = 1'b0;

        // R6/R8: release, Halt then held wake to Working
        expect_ev(EV_HALT, "R6 fresh halt");
        stpclk_n = 1'b1;
        step(1);
        check("R6 pstate halt", pstate, 1);
        step(1);
        check("R8 wake serviced", pstate, 0);

        // R3: stop-clock beats halt instruction
        expect_ev(EV_SGNT, "R3 sgnt cycle");
        stpclk_n  = 1'b0;
        halt_exec = 1'b1;
        step(1);
        halt_exec = 1'b0;
        check("R3 pstate sgnt", pstate, 2);
        step(1);
        expect_ev(EV_HALT, "R6 halt again");
        stpclk_n = 1'b1;
        step(1);
        check("R6 pstate", pstate, 1);
        step(1);
        check("R6 stays halt", pstate, 1);

        // R7: reset-source wake (bit 1), bus connected, no connect
        wake_src = 6'b000010;
        step(1);
        wake_src = '0;
        check("R7 pstate work2", pstate, 0);
        step(3);
        check("R10 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        finish_run();
    end

endmodule